// File: doc/BRIEF.md
# Interleave Reference Zone Locator and Rescaler

This block prepares the reference value of one converter leg so that the leg can be modulated against a single shared fast triangular carrier and still switch as if it owned its own phase-shifted carrier. The unsigned reference spans `n` equal zones of `MODULUS` counts each. On every sample strobe the block finds which zone the reference lies in. It then keeps only the position inside that zone, which is the same as subtracting a zone-dependent offset and scaling by `n`. When the zone number is even it mirrors that position, because there the shared carrier has the opposite phase to the one the leg would have needed.

The three results are the zone code, an invert flag and the rescaled reference in carrier counts. They are captured together in one register stage. Downstream logic compares the rescaled value against the carrier. It uses the invert flag to restore the polarity of the comparison result, and it uses the zone code to mask crossings that fall outside the leg's own zone. The active leg count `n` is a run-time input and may change between samples.

Top module: `rzr_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `zone_o` is 1, `invert_o` is 0 and `ref_scaled_o` is 0.
- R2: For a sample with `ref_i < n_eff*MODULUS`, `zone_o` equals `ref_i / MODULUS + 1` (integer division). Zones are numbered upward from 1.
- R3: In an odd zone, `ref_scaled_o` equals `ref_i mod MODULUS` and `invert_o` is 0.
- R4: In an even zone, `ref_scaled_o` equals `MODULUS-1-(ref_i mod MODULUS)` and `invert_o` is 1.
- R5: A sample with `ref_i >= n_eff*MODULUS` saturates. `zone_o` becomes `n_eff`, and the in-zone position is taken as `MODULUS-1` before any mirroring. The output is therefore `MODULUS-1` when `n_eff` is odd and 0 when it is even.
- R6: Each sample is taken at the rising clock edge where `strobe_i` is 1. All three outputs show that sample's result together from that edge onward, which is a latency of one cycle. A reference that moves into another zone takes the new mapping at its next sample.
- R7: At a rising edge where `strobe_i` is 0, all three outputs keep their values, whatever `ref_i` and `n_legs_i` do.
- R8: The effective leg count `n_eff` is 1 when `n_legs_i` is 0. It is `NMAX` when `n_legs_i` is greater than `NMAX`. Otherwise it is `n_legs_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample enable; the reference is captured at an edge where this is 1 |
| n_legs_i | input | ZONE_W (4) | Requested number of zones (parallel legs) |
| ref_i | input | REF_W (16) | Unsigned reference, MODULUS counts per zone |
| zone_o | output | ZONE_W (4) | Zone number of the last sample, 1 to n_eff |
| invert_o | output | 1 | 1 when the last sample's zone is even |
| ref_scaled_o | output | CNT_W (12) | Rescaled, possibly mirrored reference in carrier counts |

## Verification
Every result appears one cycle after the strobed edge. The zone code, the invert flag and the rescaled value all become valid at the same edge. The bench changes inputs on the falling edge. Its integer model updates its expectation at the same rising edge where the design samples. All three outputs are compared on the following falling edge in every cycle, so results are checked both on the first cycle after a sample and on cycles where no strobe arrived. Zone boundaries at plus and minus one count, saturation and out-of-range leg counts are driven as explicit patterns before a random run.

// File: rtl/rzr_pkg.sv
package rzr_pkg;

  // Clamp a requested leg count into the supported range 1..nmax.
  function automatic int unsigned legs_effective(int unsigned req, int unsigned nmax);
    if (req == 0) return 1;
    if (req > nmax) return nmax;
    return req;
  endfunction

  // Mirror an in-zone position when the zone number is even.
  function automatic int unsigned fold_position(int unsigned pos, int unsigned zone,
                                                int unsigned modulus);
    if ((zone % 2) == 0) return modulus - 1 - pos;
    return pos;
  endfunction

endpackage

// File: rtl/rzr_leg_clamp.sv
module rzr_leg_clamp #(
  parameter int NMAX   = 8,
  parameter int ZONE_W = 4
) (
  input  logic [ZONE_W-1:0] n_req_i,
  output logic [ZONE_W-1:0] n_eff_o
);
  localparam logic [ZONE_W-1:0] TOP = ZONE_W'(NMAX);

  always_comb begin
    if (n_req_i == '0)     n_eff_o = ZONE_W'(1);
    else if (n_req_i > TOP) n_eff_o = TOP;
    else                    n_eff_o = n_req_i;
  end
endmodule

// File: rtl/rzr_zone_find.sv
module rzr_zone_find #(
  parameter int NMAX    = 8,
  parameter int MODULUS = 4096,
  parameter int REF_W   = 16,
  parameter int ZONE_W  = 4
) (
  input  logic [REF_W-1:0]  ref_i,
  input  logic [ZONE_W-1:0] n_eff_i,
  output logic [ZONE_W-1:0] zone_o,
  output logic              sat_o,
  output logic [REF_W-1:0]  base_o
);
  // Thermometer of thresholds k*MODULUS crossed, limited to active zones.
  logic [NMAX-2:0] above;

  for (genvar k = 1; k < NMAX; k++) begin : g_thr
    localparam logic [REF_W-1:0]  TH = REF_W'(k * MODULUS);
    localparam logic [ZONE_W-1:0] KZ = ZONE_W'(k);
    assign above[k-1] = (ref_i >= TH) && (KZ < n_eff_i);
  end

  logic [31:0] span;
  logic [31:0] base_wide;

  always_comb begin
    zone_o = ZONE_W'(1);
    for (int i = 0; i < NMAX - 1; i++) begin
      if (above[i]) zone_o = zone_o + ZONE_W'(1);
    end
    span      = 32'(n_eff_i) * 32'(MODULUS);
    sat_o     = 32'(ref_i) >= span;
    base_wide = 32'(zone_o - ZONE_W'(1)) * 32'(MODULUS);
    base_o    = base_wide[REF_W-1:0];
  end
endmodule

// File: rtl/rzr_fold.sv
module rzr_fold #(
  parameter int MODULUS = 4096,
  parameter int REF_W   = 16,
  parameter int ZONE_W  = 4,
  parameter int CNT_W   = 12
) (
  input  logic [REF_W-1:0]  ref_i,
  input  logic [REF_W-1:0]  base_i,
  input  logic              sat_i,
  input  logic [ZONE_W-1:0] zone_i,
  output logic [CNT_W-1:0]  local_o,
  output logic              invert_o,
  output logic [CNT_W-1:0]  scaled_o
);
  localparam logic [CNT_W-1:0] TOPCNT = CNT_W'(MODULUS - 1);

  logic [REF_W-1:0] diff;

  always_comb begin
    diff     = ref_i - base_i;
    local_o  = sat_i ? TOPCNT : diff[CNT_W-1:0];
    invert_o = ~zone_i[0];
    scaled_o = invert_o ? (TOPCNT - local_o) : local_o;
  end
endmodule

// File: rtl/rzr_top.sv
module rzr_top #(
  parameter int NMAX    = 8,
  parameter int MODULUS = 4096,
  localparam int REF_W  = $clog2(NMAX * MODULUS + 1),
  localparam int ZONE_W = $clog2(NMAX + 1),
  localparam int CNT_W  = $clog2(MODULUS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [ZONE_W-1:0] n_legs_i,
  input  logic [REF_W-1:0]  ref_i,
  output logic [ZONE_W-1:0] zone_o,
  output logic              invert_o,
  output logic [CNT_W-1:0]  ref_scaled_o
);
  localparam logic [CNT_W-1:0] TOPCNT = CNT_W'(MODULUS - 1);

  // Named internal events, visible to the assertions below.
  logic [ZONE_W-1:0] n_eff_w;
  logic [ZONE_W-1:0] zone_w;
  logic              sat_w;
  logic [REF_W-1:0]  base_w;
  logic [CNT_W-1:0]  local_w;
  logic              invert_w;
  logic [CNT_W-1:0]  scaled_w;

  rzr_leg_clamp #(.NMAX(NMAX), .ZONE_W(ZONE_W)) u_clamp (
    .n_req_i (n_legs_i),
    .n_eff_o (n_eff_w)
  );

  rzr_zone_find #(.NMAX(NMAX), .MODULUS(MODULUS), .REF_W(REF_W), .ZONE_W(ZONE_W)) u_find (
    .ref_i   (ref_i),
    .n_eff_i (n_eff_w),
    .zone_o  (zone_w),
    .sat_o   (sat_w),
    .base_o  (base_w)
  );

  rzr_fold #(.MODULUS(MODULUS), .REF_W(REF_W), .ZONE_W(ZONE_W), .CNT_W(CNT_W)) u_fold (
    .ref_i    (ref_i),
    .base_i   (base_w),
    .sat_i    (sat_w),
    .zone_i   (zone_w),
    .local_o  (local_w),
    .invert_o (invert_w),
    .scaled_o (scaled_w)
  );

  // One register stage so all three results move together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zone_o       <= ZONE_W'(1);
      invert_o     <= 1'b0;
      ref_scaled_o <= '0;
    end else if (strobe_i) begin
      zone_o       <= zone_w;
      invert_o     <= invert_w;
      ref_scaled_o <= scaled_w;
    end
  end

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> $stable(zone_o) && $stable(invert_o) && $stable(ref_scaled_o)); // R7

  AST_ZONE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    zone_o >= ZONE_W'(1) && zone_o <= ZONE_W'(NMAX)); // R2

  AST_ZONE_WITHIN_LEGS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> zone_o <= $past(n_eff_w)); // R8

  AST_INV_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    invert_o == ~zone_o[0]); // R4

  AST_ODD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && !sat_w && zone_w[0] |=> ref_scaled_o == $past(local_w) && !invert_o); // R3

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && sat_w |=> zone_o == $past(n_eff_w) &&
      ref_scaled_o == (zone_o[0] ? TOPCNT : CNT_W'(0))); // R5
endmodule

// File: tb/rzr_top_tb.sv
module rzr_top_tb;
  localparam int NMAX    = 8;
  localparam int MODULUS = 4096;
  localparam int REF_W   = $clog2(NMAX * MODULUS + 1);
  localparam int ZONE_W  = $clog2(NMAX + 1);
  localparam int CNT_W   = $clog2(MODULUS);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              strobe_i = 1'b0;
  logic [ZONE_W-1:0] n_legs_i = '0;
  logic [REF_W-1:0]  ref_i = '0;
  logic [ZONE_W-1:0] zone_o;
  logic              invert_o;
  logic [CNT_W-1:0]  ref_scaled_o;

  int checks = 0;
  int fails  = 0;
  bit checking = 0;

  always #10 clk = ~clk; // 50 MHz

  rzr_top #(.NMAX(NMAX), .MODULUS(MODULUS)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .n_legs_i(n_legs_i),
    .ref_i(ref_i), .zone_o(zone_o), .invert_o(invert_o), .ref_scaled_o(ref_scaled_o)
  );

  // Behavioural model state
  int    exp_zone = 1;
  int    exp_inv  = 0;
  int    exp_sc   = 0;
  bit    fresh    = 0;
  string exp_tag  = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_zone = 1; exp_inv = 0; exp_sc = 0; fresh = 0; exp_tag = "R1";
    end else if (strobe_i) begin
      int ne, r, pos;
      bit sat;
      r  = int'(ref_i);
      ne = int'(n_legs_i);
      exp_tag = "R2";
      if (ne == 0) begin ne = 1; exp_tag = "R8"; end
      else if (ne > NMAX) begin ne = NMAX; exp_tag = "R8"; end
      sat = (r >= ne * MODULUS);
      if (sat) begin
        exp_zone = ne; pos = MODULUS - 1; exp_tag = "R5";
      end else begin
        exp_zone = r / MODULUS + 1; pos = r % MODULUS;
      end
      exp_inv = (exp_zone % 2 == 0) ? 1 : 0;
      exp_sc  = exp_inv ? (MODULUS - 1 - pos) : pos;
      if (!sat && exp_tag == "R2") exp_tag = exp_inv ? "R4" : "R3";
      fresh = 1;
    end else begin
      fresh = 0;
    end
  end

  task automatic compare(string tag);
    checks++;
    if (int'(zone_o) != exp_zone || int'(invert_o) != exp_inv || int'(ref_scaled_o) != exp_sc) begin
      fails++;
      $display("FAIL %s zone/inv/scaled got %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, zone_o, invert_o, ref_scaled_o, exp_zone, exp_inv, exp_sc);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      if (fresh) compare({"R6 ", exp_tag});
      else       compare("R7 hold");
    end
  end

  task automatic drive(int n, int r, bit stb);
    @(negedge clk);
    n_legs_i = ZONE_W'(n);
    ref_i    = REF_W'(r);
    strobe_i = stb;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int nlist[6] = '{1, 2, 3, 4, 5, 8};
    // R1: reset state, while reset is held and right after release
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");
    checking = 1;

    // R2 R3 R4 R5: every zone boundary at -1, 0, +1
    foreach (nlist[i]) begin
      for (int z = 0; z <= nlist[i]; z++) begin
        for (int d = -1; d <= 1; d++) begin
          int v = z * MODULUS + d;
          if (v >= 0 && v < (1 << REF_W)) drive(nlist[i], v, 1'b1);
        end
      end
    end

    // R7: no strobe, inputs wander
    drive(3, 5000, 1'b1);
    for (int k = 0; k < 6; k++) drive(k + 1, k * 3001, 1'b0);

    // R5: far above range, odd and even top zones
    drive(3, 65535, 1'b1);
    drive(4, 65535, 1'b1);
    drive(8, 32768, 1'b1);

    // R8: out-of-range leg counts
    drive(0, 0, 1'b1);
    drive(0, 100, 1'b1);
    drive(0, 4096, 1'b1);
    drive(9, 7 * MODULUS + 9, 1'b1);
    drive(15, 9 * MODULUS, 1'b1);
    drive(12, 3 * MODULUS + 17, 1'b1);

    // R6: zone crossing on consecutive samples
    drive(3, 4095, 1'b1);
    drive(3, 4096, 1'b1);
    drive(3, 8192, 1'b1);
    drive(3, 8191, 1'b1);

    // Random mix of strobes and gaps
    for (int k = 0; k < 400; k++)
      drive(int'($urandom_range(0, 15)), int'($urandom_range(0, 65535)),
            ($urandom_range(0, 3) != 0));
    drive(2, 0, 1'b0);
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule